// File: doc/BRIEF.md
# I2C Client SCL Low-Time Watchdog

This block sits beside an I2C client and guards it against a bus whose clock line is stuck or held low for too long. It follows the sampled SCL level together with the START and STOP detect pulses from the client's bus-condition detector. A free-running prescaler turns the system clock into a millisecond tick, and two timers work from that tick. The first measures one unbroken stretch of SCL low. The second adds up every low stretch inside one transaction. Each timer has its own enable input.

When either timer expires, the block emits a one-cycle release pulse. The client uses it to let go of any clock stretch and to send its protocol state machine back to idle. A status output stays high while the expired condition remains. The block never clears interrupt flags. It also produces the stop-received indication for a transaction that matched the address, and a timeout in that transaction does not suppress it.

Continuous timer states: `LM_IDLE` (SCL high or timer disabled), `LM_COUNT` (SCL low, counting ticks), `LM_FIRED` (expired, waiting for SCL to go high). Transitions: start-low (`LM_IDLE`→`LM_COUNT` when enabled and SCL low), break (`LM_COUNT`→`LM_IDLE` when SCL goes high or the timer is disabled), expire (`LM_COUNT`→`LM_FIRED` on the tick that completes `LOW_TICKS`), rearm (`LM_FIRED`→`LM_IDLE` when SCL goes high or the timer is disabled).
Cumulative timer states: `EX_IDLE` (no transaction), `EX_RUN` (inside a transaction, accumulating), `EX_FIRED` (expired). Transitions: open (`EX_IDLE`→`EX_RUN` on START while enabled), close (`EX_RUN`/`EX_FIRED`→`EX_IDLE` on STOP or disable), expire (`EX_RUN`→`EX_FIRED` when the count passes `EXT_TICKS`), reopen (`EX_FIRED`→`EX_RUN` on a new START).

Top module: `sclto_monitor`

## Requirements
- R1: After reset, `release_rst_o`, `timeout_o` and `stop_flag_o` are 0.
- R2: With `low_to_en_i`=1, an unbroken SCL low produces a release pulse between `LOW_TICKS`-1 and `LOW_TICKS` tick periods after the fall. The default is 30 ticks of 1 ms, inside the permitted 25 ms to 35 ms window.
- R3: Any cycle with SCL high restarts the continuous measurement. Two low stretches that are each shorter than the limit never fire, whatever their sum.
- R4: The continuous timer fires once per low stretch, however long SCL stays low. It fires again only after SCL has been high.
- R5: With `ext_to_en_i`=1, the ticks that fall while SCL is low are summed from a START that opens a transaction. The pulse comes on the tick that takes the sum above `EXT_TICKS` (default 25). High periods add nothing, and a repeated START does not clear the sum.
- R6: A STOP ends the transaction and clears the sum. The next START begins again from zero.
- R7: A timer whose enable is 0 never produces a pulse.
- R8: `stop_flag_o` pulses for one cycle, one cycle after a STOP, when `addr_match_i` was seen since the previous STOP. This holds even if a timeout fired in that transaction. Without an address match there is no pulse.
- R9: `timeout_o` is 1 from the release pulse onward. It stays 1 until the expired timer is cleared: SCL high for the continuous timer, START or STOP for the cumulative one.
- R10: After a cumulative timeout, no further pulse comes from that timer until a START or STOP clears it, even if SCL is low again.
- R11: `release_rst_o` is a single-cycle pulse, and the block has no output that clears flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized SCL level |
| start_det_i | input | 1 | One-cycle START detect |
| stop_det_i | input | 1 | One-cycle STOP detect |
| addr_match_i | input | 1 | Client address recognized |
| low_to_en_i | input | 1 | Continuous low timeout enable |
| ext_to_en_i | input | 1 | Cumulative transaction timeout enable |
| release_rst_o | output | 1 | Pulse: release clock stretch and reset protocol FSM |
| timeout_o | output | 1 | Timeout condition currently held |
| stop_flag_o | output | 1 | Stop-received pulse for an addressed transaction |

## Verification
The embedded properties assume that START and STOP never arrive in the same cycle and that each is a single-cycle pulse, as a bus-condition detector delivers them. The stimulus always raises START and STOP in separate tasks, each for exactly one cycle. It drives SCL in whole multiples of the tick period, so each low stretch contains a known number of ticks. Edge-sensitive checks can therefore count exact totals, and the continuous check allows only the one-tick uncertainty that comes from the phase of the free-running prescaler.

// File: rtl/sclto_pkg.sv
package sclto_pkg;

    typedef enum logic [1:0] {
        LM_IDLE  = 2'd0,
        LM_COUNT = 2'd1,
        LM_FIRED = 2'd2
    } low_state_e;

    typedef enum logic [1:0] {
        EX_IDLE  = 2'd0,
        EX_RUN   = 2'd1,
        EX_FIRED = 2'd2
    } ext_state_e;

endpackage

// File: rtl/sclto_tick_gen.sv
module sclto_tick_gen #(
    parameter int CLK_HZ  = 48_000_000,
    parameter int TICK_HZ = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DIV = CLK_HZ / TICK_HZ;
    localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] div_q;
    logic          wrap;

    assign wrap = (div_q == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            div_q  <= wrap ? '0 : div_q + 1'b1;
            tick_o <= wrap;
        end
    end

    // R2: the tick is a lone pulse, one per prescaler period
    a_r2_tick_single : assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/sclto_low_timer.sv
module sclto_low_timer
    import sclto_pkg::*;
#(
    parameter int LIMIT = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic scl_i,
    input  logic tick_i,
    output logic fire_o,
    output logic fired_o
);
    localparam int CW = $clog2(LIMIT + 1);

    low_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          hit;

    assign hit = tick_i && (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LM_IDLE:  if (en_i && !scl_i) st_d = LM_COUNT;
            LM_COUNT: begin
                if (!en_i || scl_i) st_d = LM_IDLE;
                else if (hit)       st_d = LM_FIRED;
            end
            LM_FIRED: if (!en_i || scl_i) st_d = LM_IDLE;
            default:  st_d = LM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LM_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d != LM_COUNT)
                cnt_q <= '0;
            else if (st_q == LM_COUNT && tick_i)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fire_o <= 1'b0;
        else        fire_o <= (st_q == LM_COUNT) && (st_d == LM_FIRED);
    end

    assign fired_o = (st_q == LM_FIRED);

    // R4: one pulse per low stretch
    a_r4_single_fire : assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
    // R3: a high SCL cycle forbids a pulse next cycle
    a_r3_high_no_fire : assert property (@(posedge clk) disable iff (!rst_n)
        scl_i |=> !fire_o);
    // R7: disabled timer stays silent
    a_r7_low_disabled : assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !fire_o);

endmodule

// File: rtl/sclto_ext_timer.sv
module sclto_ext_timer
    import sclto_pkg::*;
#(
    parameter int LIMIT = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic scl_i,
    input  logic tick_i,
    input  logic start_i,
    input  logic stop_i,
    output logic fire_o,
    output logic fired_o
);
    localparam int CW = $clog2(LIMIT + 2);

    ext_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          low_tick;
    logic          hit;

    assign low_tick = tick_i && !scl_i;
    assign hit      = low_tick && (cnt_q == CW'(LIMIT));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EX_IDLE:  if (en_i && start_i) st_d = EX_RUN;
            EX_RUN: begin
                if (!en_i || stop_i) st_d = EX_IDLE;
                else if (hit)        st_d = EX_FIRED;
            end
            EX_FIRED: begin
                if (!en_i || stop_i) st_d = EX_IDLE;
                else if (start_i)    st_d = EX_RUN;
            end
            default:  st_d = EX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= EX_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q != EX_RUN || st_d != EX_RUN)
                cnt_q <= '0;
            else if (low_tick)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fire_o <= 1'b0;
        else        fire_o <= (st_q == EX_RUN) && (st_d == EX_FIRED);
    end

    assign fired_o = (st_q == EX_FIRED);

    // R6: a STOP closes the transaction before any pulse
    a_r6_stop_no_fire : assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !fire_o);
    // R7: disabled cumulative timer stays silent
    a_r7_ext_disabled : assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !fire_o);
    // R10: after expiry the timer holds until cleared
    a_r10_hold_fired : assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
    // R6: START and STOP are expected as separate cycles
    a_r6_start_stop_apart : assert property (@(posedge clk) disable iff (!rst_n)
        !(start_i && stop_i));

endmodule

// File: rtl/sclto_stop_tracker.sv
module sclto_stop_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_match_i,
    input  logic stop_i,
    output logic stop_flag_o
);
    logic addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= 1'b0;
            stop_flag_o <= 1'b0;
        end else begin
            addr_q      <= stop_i ? 1'b0 : (addr_q | addr_match_i);
            stop_flag_o <= stop_i && (addr_q || addr_match_i);
        end
    end

    // R8: the flag only follows a STOP
    a_r8_flag_after_stop : assert property (@(posedge clk) disable iff (!rst_n)
        stop_flag_o |-> $past(stop_i));

endmodule

// File: rtl/sclto_monitor.sv
module sclto_monitor #(
    parameter int CLK_HZ    = 48_000_000,
    parameter int TICK_HZ   = 1000,
    parameter int LOW_TICKS = 30,
    parameter int EXT_TICKS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic start_det_i,
    input  logic stop_det_i,
    input  logic addr_match_i,
    input  logic low_to_en_i,
    input  logic ext_to_en_i,
    output logic release_rst_o,
    output logic timeout_o,
    output logic stop_flag_o
);
    logic tick;
    logic low_fire, low_fired;
    logic ext_fire, ext_fired;

    sclto_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    sclto_low_timer #(.LIMIT(LOW_TICKS)) u_low (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (low_to_en_i),
        .scl_i   (scl_i),
        .tick_i  (tick),
        .fire_o  (low_fire),
        .fired_o (low_fired)
    );

    sclto_ext_timer #(.LIMIT(EXT_TICKS)) u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (ext_to_en_i),
        .scl_i   (scl_i),
        .tick_i  (tick),
        .start_i (start_det_i),
        .stop_i  (stop_det_i),
        .fire_o  (ext_fire),
        .fired_o (ext_fired)
    );

    sclto_stop_tracker u_stop (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_match_i (addr_match_i),
        .stop_i       (stop_det_i),
        .stop_flag_o  (stop_flag_o)
    );

    assign release_rst_o = low_fire | ext_fire;
    assign timeout_o     = low_fired | ext_fired;

    // R9: status accompanies every release pulse
    a_r9_status_with_pulse : assert property (@(posedge clk) disable iff (!rst_n)
        release_rst_o |-> timeout_o);
    // R11: the release output is a lone pulse
    a_r11_pulse_width : assert property (@(posedge clk) disable iff (!rst_n)
        release_rst_o |=> !release_rst_o);

endmodule

// File: tb/sclto_monitor_tb.sv
module sclto_monitor_tb;
    localparam int DIV   = 10;
    localparam int LOW_T = 30;
    localparam int EXT_T = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, start = 1'b0, stop = 1'b0, amatch = 1'b0;
    logic len = 1'b0, xen = 1'b0;
    logic rel, tout, sflag;

    int checks = 0, fails = 0, cyc = 0;
    int pulses = 0, last_pulse = 0, flags = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sclto_monitor #(.CLK_HZ(DIV * 1000), .TICK_HZ(1000),
                    .LOW_TICKS(LOW_T), .EXT_TICKS(EXT_T)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .start_det_i(start),
        .stop_det_i(stop), .addr_match_i(amatch), .low_to_en_i(len),
        .ext_to_en_i(xen), .release_rst_o(rel), .timeout_o(tout),
        .stop_flag_o(sflag)
    );

    always @(negedge clk) begin
        cyc++;
        if (rst_n && rel)   begin pulses++; last_pulse = cyc; end
        if (rst_n && sflag) flags++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop = 1'b1;
        @(negedge clk) stop = 1'b0;
    endtask

    task automatic low_for(input int ticks);
        @(negedge clk) scl = 1'b0;
        wait_cyc(ticks * DIV - 1);
        @(negedge clk) scl = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        wait_cyc(3);
        chk(rel == 0 && tout == 0 && sflag == 0, "R1 reset outputs", {rel, tout, sflag}, 0);
        rst_n = 1'b1;
        wait_cyc(2);
    endtask

    task automatic t_cont_timeout();
        int p0, t0;
        len = 1'b1; xen = 1'b0;
        p0 = pulses;
        @(negedge clk) scl = 1'b0;
        t0 = cyc;
        wait_cyc((LOW_T + 1) * DIV);
        chk(pulses == p0 + 1, "R2 one pulse on long low", pulses - p0, 1);
        chk(last_pulse - t0 >= (LOW_T - 1) * DIV - 1 && last_pulse - t0 <= LOW_T * DIV + 3,
            "R2 pulse time window", last_pulse - t0, LOW_T * DIV);
        chk(tout == 1, "R9 status held while low", tout, 1);
        wait_cyc(40 * DIV);
        chk(pulses == p0 + 1, "R4 no repeat while low", pulses - p0, 1);
        @(negedge clk) scl = 1'b1;
        wait_cyc(2);
        chk(tout == 0, "R9 status clears on SCL high", tout, 0);
        low_for(LOW_T + 2);
        chk(pulses == p0 + 2, "R4 rearm after SCL high", pulses - p0, 2);
        wait_cyc(3);
    endtask

    task automatic t_cont_break();
        int p0;
        len = 1'b1; xen = 1'b0;
        p0 = pulses;
        low_for(20);
        wait_cyc(2);
        low_for(20);
        wait_cyc(3);
        chk(pulses == p0, "R3 high break restarts count", pulses - p0, 0);
    endtask

    task automatic t_ext_accum();
        int p0;
        len = 1'b0; xen = 1'b1;
        p0 = pulses;
        pulse_start();
        low_for(10); wait_cyc(40 * DIV);
        pulse_start();
        low_for(10); wait_cyc(40 * DIV);
        chk(pulses == p0, "R5 twenty low ticks no pulse", pulses - p0, 0);
        low_for(10);
        wait_cyc(3);
        chk(pulses == p0 + 1, "R5 pulse after sum passes limit", pulses - p0, 1);
        chk(tout == 1, "R9 cumulative status held", tout, 1);
        low_for(30);
        wait_cyc(3);
        chk(pulses == p0 + 1, "R10 no second pulse before clear", pulses - p0, 1);
        pulse_stop();
        wait_cyc(2);
        chk(tout == 0, "R9 status clears on STOP", tout, 0);
    endtask

    task automatic t_ext_clear();
        int p0;
        len = 1'b0; xen = 1'b1;
        p0 = pulses;
        pulse_start();
        low_for(10);
        pulse_stop();
        pulse_start();
        low_for(10); wait_cyc(5);
        low_for(10);
        wait_cyc(3);
        chk(pulses == p0, "R6 STOP clears the sum", pulses - p0, 0);
        pulse_stop();
        wait_cyc(2);
    endtask

    task automatic t_disabled();
        int p0;
        len = 1'b0; xen = 1'b0;
        p0 = pulses;
        pulse_start();
        low_for(LOW_T + 10);
        wait_cyc(3);
        chk(pulses == p0, "R7 disabled timers silent", pulses - p0, 0);
        chk(tout == 0, "R7 disabled status low", tout, 0);
        pulse_stop();
        wait_cyc(2);
    endtask

    task automatic t_stop_flag();
        int f0, p0;
        len = 1'b0; xen = 1'b1;
        f0 = flags; p0 = pulses;
        pulse_start();
        @(negedge clk) amatch = 1'b1;
        @(negedge clk) amatch = 1'b0;
        low_for(EXT_T + 5);
        wait_cyc(3);
        chk(pulses == p0 + 1, "R8 timeout occurred first", pulses - p0, 1);
        pulse_stop();
        wait_cyc(2);
        chk(flags == f0 + 1, "R8 flag after timeout with address", flags - f0, 1);
        pulse_start();
        low_for(3);
        pulse_stop();
        wait_cyc(2);
        chk(flags == f0 + 1, "R8 no flag without address", flags - f0, 1);
    endtask

    initial begin
        t_reset();
        t_cont_timeout();
        t_cont_break();
        t_ext_accum();
        t_ext_clear();
        t_disabled();
        t_stop_flag();
        chk(pulses == 4, "R11 total single-cycle pulses", pulses, 4);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all requirements actual=hung expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule